// File: doc/BRIEF.md
# UART Link with Two-Way Clear-to-Send Handshaking

This block is a byte-wide serial transceiver (one start bit, eight data bits sent least significant first, one stop bit, no parity) that paces its traffic in both directions with active-high clear-to-send lines. A divider sets every bit period to `CLK_DIV` clock cycles. The far end's clear-to-send input passes through a two-stage synchroniser. The transmitter starts a new byte only while that synchronised line is high. A byte already leaving the pin always completes.

Received bytes go into an internal first-in first-out store of `RXBUF_DEPTH` bytes. The host drains it through a valid/acknowledge pair. The block drives its own clear-to-send output low while the store holds `CTS_THRESH` or more bytes, so the far end stops before the store overruns. A byte that arrives while the store is completely full is discarded, and a sticky overflow flag records the loss until the host clears it.

Top module: `uart_cts_link`

## Requirements
- R1: In the first cycle after reset is released, `txd_o` is 1, `local_cts_o` is 1, `rx_valid_o` is 0, `rx_ovf_o` is 0 and `tx_ready_o` is 0.
- R2: A byte accepted for transmission appears on `txd_o` as a 0 start bit, then the eight data bits with bit 0 first, then a 1 stop bit. Each bit lasts `CLK_DIV` cycles, and the start bit begins in the cycle after acceptance.
- R3: `tx_ready_o` is 1 exactly when the transmitter is idle and the synchronised far-end clear-to-send is 1. A write (`tx_we_i`) is taken only in a cycle where `tx_ready_o` is 1. A write made while it is 0 has no effect on `txd_o`.
- R4: `peer_cts_i` passes through two flops that reset to 0. A change on it reaches `tx_ready_o` after the second rising clock edge and not after the first.
- R5: If `peer_cts_i` falls while a byte is being sent, that byte is sent in full. No new byte starts while the synchronised line is 0, and `txd_o` stays at 1.
- R6: `rxd_i` is synchronised through two flops. A start bit is accepted only if the line is still low half a bit period after the falling edge. A shorter low pulse produces no byte. Data bits are sampled at their middle.
- R7: `rx_valid_o` is 1 whenever the store is not empty, with `rx_data_o` showing the oldest byte. While `rx_valid_o` is 1 and `rx_ack_i` is 0, `rx_data_o` holds its value. A cycle with `rx_ack_i` at 1 removes that byte, and bytes leave in arrival order.
- R8: `local_cts_o` is registered from the store's occupancy. It is 0 while the occupancy (in the cycle before) is `CTS_THRESH` (default 486) or more, and 1 otherwise.
- R9: A byte that completes while the store holds `RXBUF_DEPTH` bytes is discarded and sets `rx_ovf_o`. The flag stays 1 until `ovf_clr_i` is 1 for a cycle. The stored bytes are unaffected.
- R10: A received byte written in the same cycle that the host removes a byte leaves the occupancy unchanged. Both operations take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rxd_i | input | 1 | Serial receive line, idle high |
| txd_o | output | 1 | Serial transmit line, idle high |
| peer_cts_i | input | 1 | Far end's clear-to-send, high means this block may send |
| local_cts_o | output | 1 | This block's clear-to-send, high means the far end may send |
| tx_data_i | input | 8 | Byte to transmit |
| tx_we_i | input | 1 | Transmit write strobe |
| tx_ready_o | output | 1 | Transmitter idle and far end clear |
| rx_data_o | output | 8 | Oldest byte in the receive store |
| rx_valid_o | output | 1 | Receive store not empty |
| rx_ack_i | input | 1 | Remove the byte on `rx_data_o` |
| rx_ovf_o | output | 1 | Sticky flag: a byte was discarded because the store was full |
| ovf_clr_i | input | 1 | Clears `rx_ovf_o` |

## Verification
The two operations that can fall in the same cycle are a byte completing on the receive side and the host removing a byte from the store. The bench fills the store to the threshold. It then starts one more incoming byte and holds the acknowledge high for a window that covers the whole frame, so the write lands in a cycle that also pops. The result is judged afterwards: filling up to the exact model capacity must not set the overflow flag, the next byte must set it, and the drained sequence must match the model byte for byte.

// File: rtl/uart_cts_pkg.sv
package uart_cts_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

endpackage

// File: rtl/uart_cts_sync.sv
module uart_cts_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx
    import uart_cts_pkg::*;
#(
    parameter int CLK_DIV = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic              txd_o,
    output logic              busy_o
);

    localparam int CNT_W   = $clog2(CLK_DIV);
    localparam int FRAME_W = BYTE_W + 2;
    localparam int BIT_W   = $clog2(FRAME_W);

    typedef struct packed {
        logic               busy;
        logic [CNT_W-1:0]   cnt;
        logic [BIT_W-1:0]   bitn;
        logic [FRAME_W-1:0] shreg;
    } tx_regs_t;

    tx_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!r_q.busy) begin
            if (start_i) begin
                r_d.busy  = 1'b1;
                r_d.cnt   = '0;
                r_d.bitn  = '0;
                // stop bit, payload, start bit; shifted out from bit 0
                r_d.shreg = {1'b1, data_i, 1'b0};
            end
        end else if (r_q.cnt == CNT_W'(CLK_DIV - 1)) begin
            r_d.cnt   = '0;
            r_d.shreg = {1'b1, r_q.shreg[FRAME_W-1:1]};
            if (r_q.bitn == BIT_W'(FRAME_W - 1)) r_d.busy = 1'b0;
            else                                 r_d.bitn = r_q.bitn + BIT_W'(1);
        end else begin
            r_d.cnt = r_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.busy  <= 1'b0;
            r_q.cnt   <= '0;
            r_q.bitn  <= '0;
            r_q.shreg <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign txd_o  = r_q.shreg[0];
    assign busy_o = r_q.busy;

endmodule

// File: rtl/uart_cts_rx.sv
module uart_cts_rx
    import uart_cts_pkg::*;
#(
    parameter int CLK_DIV = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd_i,
    output logic              byte_valid_o,
    output logic [BYTE_W-1:0] byte_o
);

    localparam int CNT_W = $clog2(CLK_DIV);
    localparam int HALF  = CLK_DIV / 2;
    localparam int IDX_W = $clog2(BYTE_W);

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  bitn;
        logic [BYTE_W-1:0] shreg;
        logic              wr;
    } rx_regs_t;

    rx_regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.wr = 1'b0;
        unique case (r_q.state)
            RX_IDLE: begin
                if (!rxd_i) begin
                    r_d.state = RX_START;
                    r_d.cnt   = '0;
                end
            end
            RX_START: begin
                if (r_q.cnt == CNT_W'(HALF - 1)) begin
                    r_d.cnt   = '0;
                    r_d.bitn  = '0;
                    // line back high at the half-bit point: a glitch
                    r_d.state = rxd_i ? RX_IDLE : RX_DATA;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            RX_DATA: begin
                if (r_q.cnt == CNT_W'(CLK_DIV - 1)) begin
                    r_d.cnt   = '0;
                    r_d.shreg = {rxd_i, r_q.shreg[BYTE_W-1:1]};
                    if (r_q.bitn == IDX_W'(BYTE_W - 1)) r_d.state = RX_STOP;
                    else                                r_d.bitn  = r_q.bitn + IDX_W'(1);
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            RX_STOP: begin
                if (r_q.cnt == CNT_W'(CLK_DIV - 1)) begin
                    r_d.cnt   = '0;
                    r_d.state = RX_IDLE;
                    r_d.wr    = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            default: r_d.state = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= RX_IDLE;
            r_q.cnt   <= '0;
            r_q.bitn  <= '0;
            r_q.shreg <= '0;
            r_q.wr    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign byte_valid_o = r_q.wr;
    assign byte_o       = r_q.shreg;

endmodule

// File: rtl/uart_cts_rxbuf.sv
module uart_cts_rxbuf
    import uart_cts_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int THRESH = 486
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              ack_i,
    output logic              valid_o,
    output logic [BYTE_W-1:0] data_o,
    input  logic              ovf_clr_i,
    output logic              ovf_o,
    output logic              cts_o
);

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int CNT_W  = ADDR_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] wp;
        logic [ADDR_W-1:0] rp;
        logic [CNT_W-1:0]  cnt;
        logic              ovf;
        logic              cts;
    } buf_regs_t;

    buf_regs_t r_d, r_q;
    logic [BYTE_W-1:0] store [DEPTH];
    logic full, empty, push, pop;

    always_comb begin
        full  = (r_q.cnt == CNT_W'(DEPTH));
        empty = (r_q.cnt == '0);
        push  = wr_i && !full;
        pop   = ack_i && !empty;

        r_d = r_q;
        if (push) r_d.wp = r_q.wp + ADDR_W'(1);
        if (pop)  r_d.rp = r_q.rp + ADDR_W'(1);
        unique case ({push, pop})
            2'b10:   r_d.cnt = r_q.cnt + CNT_W'(1);
            2'b01:   r_d.cnt = r_q.cnt - CNT_W'(1);
            default: r_d.cnt = r_q.cnt;
        endcase
        // a new loss in the same cycle as a clear keeps the flag set
        r_d.ovf = (r_q.ovf && !ovf_clr_i) || (wr_i && full);
        r_d.cts = (r_q.cnt < CNT_W'(THRESH));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.wp  <= '0;
            r_q.rp  <= '0;
            r_q.cnt <= '0;
            r_q.ovf <= 1'b0;
            r_q.cts <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) store[r_q.wp] <= wr_data_i;
    end

    assign valid_o = !empty;
    assign data_o  = store[r_q.rp];
    assign ovf_o   = r_q.ovf;
    assign cts_o   = r_q.cts;

endmodule

// File: rtl/uart_cts_link.sv
module uart_cts_link
    import uart_cts_pkg::*;
#(
    parameter int CLK_DIV     = 16,
    parameter int RXBUF_DEPTH = 512,
    parameter int CTS_THRESH  = 486,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd_i,
    output logic              txd_o,
    input  logic              peer_cts_i,
    output logic              local_cts_o,
    input  logic [BYTE_W-1:0] tx_data_i,
    input  logic              tx_we_i,
    output logic              tx_ready_o,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    input  logic              rx_ack_i,
    output logic              rx_ovf_o,
    input  logic              ovf_clr_i
);

    logic              peer_cts_sync;
    logic              rxd_sync;
    logic              tx_busy;
    logic              tx_start;
    logic              rx_wr;
    logic [BYTE_W-1:0] rx_byte;

    uart_cts_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cts_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (peer_cts_i),
        .q_o   (peer_cts_sync)
    );

    uart_cts_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rxd_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rxd_i),
        .q_o   (rxd_sync)
    );

    assign tx_ready_o = !tx_busy && peer_cts_sync;
    assign tx_start   = tx_we_i && tx_ready_o;

    uart_cts_tx #(.CLK_DIV(CLK_DIV)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tx_start),
        .data_i  (tx_data_i),
        .txd_o   (txd_o),
        .busy_o  (tx_busy)
    );

    uart_cts_rx #(.CLK_DIV(CLK_DIV)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .rxd_i        (rxd_sync),
        .byte_valid_o (rx_wr),
        .byte_o       (rx_byte)
    );

    uart_cts_rxbuf #(.DEPTH(RXBUF_DEPTH), .THRESH(CTS_THRESH)) u_rxbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (rx_wr),
        .wr_data_i (rx_byte),
        .ack_i     (rx_ack_i),
        .valid_o   (rx_valid_o),
        .data_o    (rx_data_o),
        .ovf_clr_i (ovf_clr_i),
        .ovf_o     (rx_ovf_o),
        .cts_o     (local_cts_o)
    );

endmodule

// File: rtl/uart_cts_link_chk.sv
module uart_cts_link_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       txd_o,
    input logic       tx_ready_o,
    input logic       tx_busy,
    input logic       peer_cts_sync,
    input logic       local_cts_o,
    input logic       rx_valid_o,
    input logic [7:0] rx_data_o,
    input logic       rx_ack_i,
    input logic       rx_ovf_o,
    input logic       ovf_clr_i
);

    // R3
    ready_line_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready_o |-> txd_o);

    // R5
    start_needs_cts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(peer_cts_sync));

    // R8
    cts_low_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !local_cts_o |-> rx_valid_o);

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf_o && !ovf_clr_i |=> rx_ovf_o);

    // R7
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o && !rx_ack_i |=> rx_valid_o && $stable(rx_data_o));

endmodule

bind uart_cts_link uart_cts_link_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .txd_o         (txd_o),
    .tx_ready_o    (tx_ready_o),
    .tx_busy       (tx_busy),
    .peer_cts_sync (peer_cts_sync),
    .local_cts_o   (local_cts_o),
    .rx_valid_o    (rx_valid_o),
    .rx_data_o     (rx_data_o),
    .rx_ack_i      (rx_ack_i),
    .rx_ovf_o      (rx_ovf_o),
    .ovf_clr_i     (ovf_clr_i)
);

// File: tb/uart_cts_link_tb.sv
module uart_cts_link_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 8;
    localparam int DEPTH      = 512;
    localparam int THRESH     = 486;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd_i = 1'b1;
    logic       txd_o;
    logic       peer_cts_i = 1'b1;
    logic       local_cts_o;
    logic [7:0] tx_data_i = '0;
    logic       tx_we_i = 1'b0;
    logic       tx_ready_o;
    logic [7:0] rx_data_o;
    logic       rx_valid_o;
    logic       rx_ack_i = 1'b0;
    logic       rx_ovf_o;
    logic       ovf_clr_i = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int sent_idx = 0;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_cts_link #(.CLK_DIV(DIV), .RXBUF_DEPTH(DEPTH), .CTS_THRESH(THRESH)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rxd_i       (rxd_i),
        .txd_o       (txd_o),
        .peer_cts_i  (peer_cts_i),
        .local_cts_o (local_cts_o),
        .tx_data_i   (tx_data_i),
        .tx_we_i     (tx_we_i),
        .tx_ready_o  (tx_ready_o),
        .rx_data_o   (rx_data_o),
        .rx_valid_o  (rx_valid_o),
        .rx_ack_i    (rx_ack_i),
        .rx_ovf_o    (rx_ovf_o),
        .ovf_clr_i   (ovf_clr_i)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 29) + 7);
    endfunction

    // drive one serial frame on rxd_i; optionally record it in the model
    task automatic send_rx(input logic [7:0] b, input bit keep);
        if (keep) exp_q.push_back(b);
        rxd_i = 1'b0;
        wait_n(DIV);
        for (int k = 0; k < 8; k++) begin
            rxd_i = b[k];
            wait_n(DIV);
        end
        rxd_i = 1'b1;
        wait_n(DIV);
    endtask

    task automatic tx_write(input logic [7:0] b);
        tx_data_i = b;
        tx_we_i   = 1'b1;
        wait_n(1);
        tx_we_i   = 1'b0;
    endtask

    task automatic capture_tx(output logic [7:0] got, output bit ok);
        int guard = 0;
        ok = 1'b1;
        while (txd_o !== 1'b0 && guard < 30 * DIV) begin
            wait_n(1);
            guard++;
        end
        if (txd_o !== 1'b0) ok = 1'b0;
        wait_n(DIV/2);
        if (txd_o !== 1'b0) ok = 1'b0;
        for (int k = 0; k < 8; k++) begin
            wait_n(DIV);
            got[k] = txd_o;
        end
        wait_n(DIV);
        if (txd_o !== 1'b1) ok = 1'b0;
    endtask

    task automatic line_quiet(input int n, output bit quiet);
        quiet = 1'b1;
        for (int k = 0; k < n; k++) begin
            if (txd_o !== 1'b1) quiet = 1'b0;
            wait_n(1);
        end
    endtask

    task automatic pop_window(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            if (rx_valid_o) begin
                logic [7:0] e;
                e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
                chk(rx_data_o === e, req, {24'h0, rx_data_o}, {24'h0, e});
                rx_ack_i = 1'b1;
            end else begin
                rx_ack_i = 1'b0;
            end
            wait_n(1);
        end
        rx_ack_i = 1'b0;
    endtask

    task automatic drain(input string req);
        int guard = 0;
        while (rx_valid_o && guard < 2 * DEPTH) begin
            logic [7:0] e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
            chk(rx_data_o === e, req, {24'h0, rx_data_o}, {24'h0, e});
            rx_ack_i = 1'b1;
            wait_n(1);
            guard++;
        end
        rx_ack_i = 1'b0;
        wait_n(1);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
        chk(rx_valid_o === 1'b0, req, {31'h0, rx_valid_o}, 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        wait_n(5);
        rst_n = 1'b1;
        chk(txd_o === 1'b1,       "R1 txd",       {31'h0, txd_o}, 1);
        chk(local_cts_o === 1'b1, "R1 local cts", {31'h0, local_cts_o}, 1);
        chk(rx_valid_o === 1'b0,  "R1 rx valid",  {31'h0, rx_valid_o}, 0);
        chk(rx_ovf_o === 1'b0,    "R1 overflow",  {31'h0, rx_ovf_o}, 0);
        chk(tx_ready_o === 1'b0,  "R1 tx ready",  {31'h0, tx_ready_o}, 0);
        wait_n(1);
        chk(tx_ready_o === 1'b0,  "R4 one edge after reset", {31'h0, tx_ready_o}, 0);
        wait_n(1);
        chk(tx_ready_o === 1'b1,  "R4 two edges after reset", {31'h0, tx_ready_o}, 1);
    endtask

    task automatic t_tx_frames;
        logic [7:0] got;
        bit ok, quiet;
        tx_write(8'hA5);
        chk(tx_ready_o === 1'b0, "R3 busy after write", {31'h0, tx_ready_o}, 0);
        tx_write(8'hFF);  // ignored: not ready
        capture_tx(got, ok);
        chk(ok, "R2 start/stop bits", {31'h0, ok}, 1);
        chk(got === 8'hA5, "R2 payload A5", {24'h0, got}, 32'hA5);
        wait_n(DIV);
        line_quiet(12 * DIV, quiet);
        chk(quiet, "R3 write while busy ignored", {31'h0, quiet}, 1);
        chk(tx_ready_o === 1'b1, "R3 ready when idle", {31'h0, tx_ready_o}, 1);
        tx_write(8'h3C);
        capture_tx(got, ok);
        chk(ok && got === 8'h3C, "R2 payload 3C", {24'h0, got}, 32'h3C);
        wait_n(2 * DIV);
    endtask

    task automatic t_cts_gate;
        logic [7:0] got;
        bit ok, quiet;
        peer_cts_i = 1'b0;
        wait_n(3);
        chk(tx_ready_o === 1'b0, "R3 ready low when peer not clear", {31'h0, tx_ready_o}, 0);
        tx_write(8'h00);
        line_quiet(12 * DIV, quiet);
        chk(quiet, "R5 no start while peer not clear", {31'h0, quiet}, 1);
        peer_cts_i = 1'b1;
        wait_n(1);
        chk(tx_ready_o === 1'b0, "R4 not after first edge", {31'h0, tx_ready_o}, 0);
        wait_n(1);
        chk(tx_ready_o === 1'b1, "R4 after second edge", {31'h0, tx_ready_o}, 1);
        tx_write(8'h96);
        fork
            capture_tx(got, ok);
            begin
                wait_n(2 * DIV);
                peer_cts_i = 1'b0;
            end
        join
        chk(ok && got === 8'h96, "R5 byte in flight completes", {24'h0, got}, 32'h96);
        wait_n(DIV);
        tx_write(8'h81);
        line_quiet(12 * DIV, quiet);
        chk(quiet && tx_ready_o === 1'b0, "R5 line held idle", {31'h0, quiet}, 1);
        peer_cts_i = 1'b1;
        wait_n(3);
    endtask

    task automatic t_rx_basic;
        rxd_i = 1'b0;
        wait_n(2);
        rxd_i = 1'b1;
        wait_n(12 * DIV);
        chk(rx_valid_o === 1'b0, "R6 short low pulse rejected", {31'h0, rx_valid_o}, 0);
        send_rx(8'h5A, 1'b1);
        send_rx(8'h01, 1'b1);
        send_rx(8'h80, 1'b1);
        wait_n(4);
        chk(rx_valid_o === 1'b1, "R7 valid when not empty", {31'h0, rx_valid_o}, 1);
        wait_n(5);
        chk(rx_data_o === 8'h5A, "R7 head held without ack", {24'h0, rx_data_o}, 32'h5A);
        drain("R6 R7 order and sampling");
    endtask

    task automatic t_fill_and_overflow;
        for (int i = 0; i < THRESH - 1; i++) begin
            send_rx(pat(sent_idx), 1'b1);
            sent_idx++;
        end
        wait_n(4);
        chk(local_cts_o === 1'b1, "R8 high below threshold", {31'h0, local_cts_o}, 1);
        send_rx(pat(sent_idx), 1'b1);
        sent_idx++;
        wait_n(4);
        chk(local_cts_o === 1'b0, "R8 low at threshold", {31'h0, local_cts_o}, 0);

        // R10: a byte lands while the host pops every cycle
        fork
            begin
                send_rx(pat(sent_idx), 1'b1);
                sent_idx++;
            end
            pop_window(12 * DIV, "R10 data during overlap");
        join
        wait_n(4);
        chk(local_cts_o === 1'b1, "R10 R8 high after pops", {31'h0, local_cts_o}, 1);

        while (exp_q.size() < DEPTH) begin
            send_rx(pat(sent_idx), 1'b1);
            sent_idx++;
        end
        wait_n(4);
        chk(rx_ovf_o === 1'b0, "R10 count exact at capacity", {31'h0, rx_ovf_o}, 0);
        chk(local_cts_o === 1'b0, "R8 low when full", {31'h0, local_cts_o}, 0);
        send_rx(8'hEE, 1'b0);
        wait_n(4);
        chk(rx_ovf_o === 1'b1, "R9 overflow set", {31'h0, rx_ovf_o}, 1);
        wait_n(10);
        chk(rx_ovf_o === 1'b1, "R9 overflow sticky", {31'h0, rx_ovf_o}, 1);
        ovf_clr_i = 1'b1;
        wait_n(1);
        ovf_clr_i = 1'b0;
        chk(rx_ovf_o === 1'b0, "R9 overflow cleared", {31'h0, rx_ovf_o}, 0);
        drain("R9 stored bytes kept, dropped byte absent");
        chk(local_cts_o === 1'b1, "R8 high after drain", {31'h0, local_cts_o}, 1);
    endtask

    bit finished = 1'b0;

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        report();
    end

    initial begin
        t_reset();
        t_tx_frames();
        t_cts_gate();
        t_rx_basic();
        t_fill_and_overflow();
        report();
    end

endmodule